// File: doc/BRIEF.md
# Filtered Record Sum Engine

The engine holds a table of fixed-format records in an on-chip memory and, on command, walks through the first N of them in index order. For every record whose location code equals a key supplied with the command, the record's sales amount is added into a private scratch accumulator. Records with any other location leave the accumulator as it is. Once the last record has been examined, the accumulator is copied into the output total register in a single write. The total is never read back or updated while the walk is in progress.

Records are loaded through a simple write port: one 48-bit word per record, addressed by record index. A one-cycle `start` pulse captures the key and the record count and begins the walk. `busy` covers the walk, and a one-cycle `done` pulse marks the cycle in which the new total first appears. The controller has five states. IDLE waits for `start`. It goes to READ, or to WRITE_TOTAL if the count is zero. READ presents the record address to the memory and always goes to CHECK. CHECK compares the location with the key, adds the sales amount on a match, and always goes to NEXT. NEXT advances the index and returns to READ, or goes to WRITE_TOTAL after the last record. WRITE_TOTAL copies the accumulator into the total and returns to IDLE.

Top module: `rsum_engine`

## Requirements
- R1: A record word carries the identifier in bits 47:40, the location code in bits 39:32, the salary in bits 31:16 and the sales amount in bits 15:0. Writing with `ld_we` high stores `ld_data` at record index `ld_addr`.
- R2: After a command with key K and count N, `total` equals the sum of the sales fields of records 0 to N-1 whose location code equals K. Identifier and salary fields have no effect on the result.
- R3: The total is 24 bits wide and does not wrap: 64 records that each hold sales 0xFFFF and a matching location produce 0x3FFFC0.
- R4: A count of zero produces a total of zero followed by `done`. A count above 64 is treated as 64.
- R5: `done` is high for exactly one cycle, and `busy` is low in that cycle. `busy` is high from the cycle after an accepted `start` until `done`.
- R6: `done` is high in the cycle that follows the (3·N'+1)-th rising edge after the edge that samples `start`, where N' is the effective count.
- R7: A `start` pulse that arrives while `busy` is high is ignored. The running command finishes with its own result and timing, and no extra `done` follows.
- R8: The key and count are captured at the accepted `start`. Changing `key` or `rec_count` afterwards does not change the running command's result.
- R9: `total` keeps its previous value throughout a command and changes only in the cycle where `done` is high.
- R10: After reset, `busy`, `done` and `total` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_we | input | 1 | Record write enable |
| ld_addr | input | 6 | Record index for a write |
| ld_data | input | 48 | Record word to store |
| start | input | 1 | Begin a command (single-cycle pulse) |
| key | input | 8 | Location code to match |
| rec_count | input | 7 | Number of records to scan (0 to 64) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| total | output | 24 | Sum of matching sales from the last command |

## Verification
A wrong accumulator or a stale key stays hidden until the end of the command, because the total is only written once. Such a fault shows up as a wrong `total` at `done`, up to 193 cycles after `start`. A fault in the controller's index or state sequence shows up sooner, as `done` arriving off the 3N+1 schedule, as an unexpected extra `done` after an ignored `start`, or as `total` moving while `busy` is high. The bench compares every `done` against a queue of independently computed totals and latencies.

// File: rtl/rsum_pkg.sv
package rsum_pkg;

    localparam int ID_W    = 8;
    localparam int LOC_W   = 8;
    localparam int SAL_W   = 16;
    localparam int SALES_W = 16;
    localparam int REC_W   = ID_W + LOC_W + SAL_W + SALES_W;

    // Field order fixes the bit layout of a loaded record word.
    typedef struct packed {
        logic [ID_W-1:0]    ident;
        logic [LOC_W-1:0]   loc;
        logic [SAL_W-1:0]   salary;
        logic [SALES_W-1:0] sales;
    } rec_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CHECK,
        ST_NEXT,
        ST_WRITE_TOTAL
    } state_t;

endpackage

// File: rtl/rsum_rec_ram.sv
module rsum_rec_ram
    import rsum_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  rec_t          wdata,
    input  logic [AW-1:0] raddr,
    output rec_t          rdata
);

    rec_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/rsum_ctrl.sv
module rsum_ctrl
    import rsum_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] rec_count,
    output logic [AW-1:0] rd_addr,
    output logic          acc_clear,
    output logic          chk_en,
    output logic          wr_total,
    output logic          busy,
    output logic          done
);

    localparam logic [CW-1:0] MAX_CNT = CW'(DEPTH);

    state_t        state_q, state_d;
    logic [AW-1:0] idx_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_in;
    logic          accept;
    logic          last_rec;

    assign cnt_in   = (rec_count > MAX_CNT) ? MAX_CNT : rec_count;
    assign accept   = (state_q == ST_IDLE) && start;
    assign last_rec = (CW'(idx_q) + CW'(1)) == cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (cnt_in == '0) ? ST_WRITE_TOTAL : ST_READ;
                end
            end
            ST_READ:        state_d = ST_CHECK;
            ST_CHECK:       state_d = ST_NEXT;
            ST_NEXT:        state_d = last_rec ? ST_WRITE_TOTAL : ST_READ;
            ST_WRITE_TOTAL: state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // Index and captured count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            cnt_q <= '0;
        end else if (accept) begin
            idx_q <= '0;
            cnt_q <= cnt_in;
        end else if (state_q == ST_NEXT) begin
            idx_q <= idx_q + AW'(1);
        end
    end

    // Completion pulse, registered so it lines up with the total write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= (state_q == ST_WRITE_TOTAL);
        end
    end

    // Outputs
    always_comb begin
        rd_addr   = idx_q;
        acc_clear = accept;
        chk_en    = 1'b0;
        wr_total  = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE:        busy     = 1'b0;
            ST_READ:        ;
            ST_CHECK:       chk_en   = 1'b1;
            ST_NEXT:        ;
            ST_WRITE_TOTAL: wr_total = 1'b1;
            default:        busy     = 1'b0;
        endcase
    end

    // R6: a record read is always followed by its check, then by NEXT
    p_read_then_check_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_READ |=> state_q == ST_CHECK);
    p_check_then_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_CHECK |=> state_q == ST_NEXT);
    // R5: busy only rises in response to start
    p_busy_from_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R8: the captured count holds while a command runs
    p_count_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cnt_q));

endmodule

// File: rtl/rsum_accum.sv
module rsum_accum
    import rsum_pkg::*;
#(
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [LOC_W-1:0] key_in,
    input  logic             chk_en,
    input  rec_t             rec,
    input  logic             wr_total,
    output logic [ACC_W-1:0] total
);

    logic [ACC_W-1:0] acc_q;
    logic [LOC_W-1:0] key_q;
    logic             hit;

    assign hit = chk_en && (rec.loc == key_q);

    // Scratch accumulator and captured key
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            key_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
            key_q <= key_in;
        end else if (hit) begin
            acc_q <= acc_q + ACC_W'(rec.sales);
        end
    end

    // Total slot, written once per command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total <= '0;
        end else if (wr_total) begin
            total <= acc_q;
        end
    end

    // R3: the scratch sum never wraps when a sales amount is added
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |=> acc_q >= $past(acc_q));
    // R1: a record under examination was loaded beforehand
    p_rec_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |-> !$isunknown(rec));

endmodule

// File: rtl/rsum_engine.sv
module rsum_engine
    import rsum_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int ACC_W = 24,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_we,
    input  logic [AW-1:0]    ld_addr,
    input  logic [REC_W-1:0] ld_data,
    input  logic             start,
    input  logic [LOC_W-1:0] key,
    input  logic [CW-1:0]    rec_count,
    output logic             busy,
    output logic             done,
    output logic [ACC_W-1:0] total
);

    logic [AW-1:0] rd_addr;
    rec_t          rd_rec;
    logic          acc_clear;
    logic          chk_en;
    logic          wr_total;

    rsum_rec_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (ld_we),
        .waddr (ld_addr),
        .wdata (rec_t'(ld_data)),
        .raddr (rd_addr),
        .rdata (rd_rec)
    );

    rsum_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rec_count (rec_count),
        .rd_addr   (rd_addr),
        .acc_clear (acc_clear),
        .chk_en    (chk_en),
        .wr_total  (wr_total),
        .busy      (busy),
        .done      (done)
    );

    rsum_accum #(.ACC_W(ACC_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (acc_clear),
        .key_in   (key),
        .chk_en   (chk_en),
        .rec      (rd_rec),
        .wr_total (wr_total),
        .total    (total)
    );

    // R5: done lasts a single cycle and never overlaps busy
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9: the total output moves only together with done
    p_total_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(total) |-> done);

endmodule

// File: tb/rsum_engine_bench.sv
module rsum_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [47:0] ld_data = '0;
    logic        start = 1'b0;
    logic [7:0]  key = '0;
    logic [6:0]  rec_count = '0;
    logic        busy;
    logic        done;
    logic [23:0] total;

    always #10 clk = ~clk;

    rsum_engine u_rsum_engine (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .start(start), .key(key), .rec_count(rec_count),
        .busy(busy), .done(done), .total(total)
    );

    typedef struct {
        logic [23:0] sum;
        int          lat;
        int          t0;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    int   cyc    = 0;
    int   m_loc   [64];
    int   m_sales [64];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // R1 layout: ident 47:40, loc 39:32, salary 31:16, sales 15:0
    task automatic load(input int i, input int id, input int loc, input int sal, input int sales);
        @(negedge clk);
        ld_we   = 1'b1;
        ld_addr = 6'(i);
        ld_data = {8'(id), 8'(loc), 16'(sal), 16'(sales)};
        m_loc[i]   = loc & 8'hFF;
        m_sales[i] = sales & 16'hFFFF;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    // Driver: issue one command, push the expected result, disturb the inputs
    task automatic run_scan(input int k, input int n, input bit twice, input string req);
        exp_t e;
        int   eff;
        longint s;
        eff = (n > 64) ? 64 : n;
        s = 0;
        for (int i = 0; i < eff; i++) begin
            if (m_loc[i] == k) s += m_sales[i];
        end
        @(negedge clk);
        key = 8'(k);
        rec_count = 7'(n);
        start = 1'b1;
        @(negedge clk);
        e.sum = 24'(s);
        e.lat = 3 * eff + 1;
        e.t0  = cyc;
        e.req = req;
        q.push_back(e);
        start = 1'b0;
        // R8: inputs change right after capture
        key = ~8'(k);
        rec_count = 7'd3;
        if (eff > 0) chk(busy === 1'b1, "R5", busy, 1);
        if (twice) begin
            repeat (3) @(negedge clk);
            // R7: start while busy with a different command
            start = 1'b1;
            key = 8'(k + 1);
            rec_count = 7'd64;
            @(negedge clk);
            start = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Monitor / scoreboard
    logic [23:0] last_total = '0;
    bit          prev_done  = 1'b0;
    bit          moved      = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (total !== last_total && done !== 1'b1) moved = 1'b1;
            if (done === 1'b1) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R7", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(total === e.sum, e.req, total, e.sum);
                    chk(cyc - e.t0 == e.lat, "R6", cyc - e.t0, e.lat);
                    chk(busy === 1'b0, "R5", busy, 0);
                    chk(!prev_done, "R5", prev_done, 0);
                    chk(!moved, "R9", moved, 0);
                end
                moved = 1'b0;
            end
            last_total = total;
            prev_done  = (done === 1'b1);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R10: reset state
        chk(busy === 1'b0, "R10", busy, 0);
        chk(done === 1'b0, "R10", done, 0);
        chk(total === 24'h0, "R10", total, 0);
        rst_n = 1'b1;

        for (int i = 0; i < 64; i++)
            load(i, 255 - i, i % 5, i * 771, (i * 1237 + 11) & 16'hFFFF);

        run_scan(2, 64, 1'b0, "R2");
        run_scan(0, 10, 1'b0, "R2");
        run_scan(7, 20, 1'b0, "R2");    // no match
        run_scan(0, 0, 1'b0, "R4");     // zero count
        run_scan(0, 1, 1'b0, "R2");     // single record
        run_scan(3, 100, 1'b0, "R4");   // clamped count
        run_scan(4, 12, 1'b1, "R7");    // start while busy
        run_scan(1, 9, 1'b0, "R8");

        // R2: identifier and salary changes do not affect the sum
        load(5, 0, m_loc[5], 16'hFFFF, m_sales[5]);
        run_scan(0, 64, 1'b0, "R2");

        // R3: full table of maximum sales, all matching
        for (int i = 0; i < 64; i++) load(i, i, 9, 0, 16'hFFFF);
        run_scan(9, 64, 1'b0, "R3");
        chk(total === 24'h3FFFC0, "R3", total, 24'h3FFFC0);

        chk(q.size() == 0, "R7", q.size(), 0);
        finish_run();
    end

endmodule